// File: doc/BRIEF.md
# Buffered SPI Byte Engine with Level Interrupts

This block moves bytes between a host register port and a 4-wire serial link. It can run as the clock-driving master or as a slave that follows an external clock. Outgoing bytes wait in a transmit ring and incoming bytes wait in a receive ring. Both rings use the same software-set window of buffer slots, bounded by a low and a high slot index. Their pointers step through that window and wrap from the high bound back to the low bound.

Software picks a fill level for each side. The transmit flag rises while the transmit ring holds fewer bytes than its level, which asks for more data. The receive flag rises once the receive ring holds more bytes than its level, which asks for a drain. The two flags are ORed onto one interrupt line, and a source register tells which side raised it. Write-one-to-clear sticky bits record a host write dropped on a full transmit ring and a received byte lost on a full receive ring.

Top module: `spi_thresh_ctrl`

## Requirements
- R1: After reset, `spi_ss_n_o` is 1, `spi_sclk_o` is 0 and `irq_o` is 0. The receive count (address 7), the transmit count (address 8) and the status register (address 9) all read 0.
- R2: In master mode (bit 0 of address 1 set), a byte written to address 0 starts an 8-bit exchange. `spi_ss_n_o` is low for exactly 16*(speed+1) clocks, where speed is the value at address 2, so SCLK has a period of 2*(speed+1) clocks. MOSI is sent MSB first, SCLK idles low, and MISO is sampled on each rising SCLK.
- R3: Each received byte enters the receive ring. A read of address 0 returns the oldest byte and lowers the count at address 7 by one. A read of address 0 while the ring is empty returns 0 and leaves the count at 0.
- R4: Status bit 0 (transmit flag) sets while the transmit count is below the transmit level at address 3, and stays clear while the count is at or above that level.
- R5: Status bit 1 (receive flag) sets when the receive count is greater than the receive level at address 4. It stays clear while the count equals that level.
- R6: Writing 1 to a status bit clears it on the next clock. If its set condition still holds, it sets again one clock later.
- R7: `irq_o` is the OR of status bits 0 and 1. Address 10 reads bit 0 = transmit flag and bit 1 = receive flag.
- R8: Addresses 5 and 6 give the low and high slot of the buffer window, so each ring holds high-low+1 bytes. Pointers wrap from the high slot to the low slot, and byte order is kept across the wrap.
- R9: A write to address 0 while the transmit ring is full is dropped and sets status bit 2.
- R10: A byte received while the receive ring is full is discarded and sets status bit 3.
- R11: Writing address 1 with bit 1 set empties the transmit ring. Writing it with bit 2 set empties the receive ring.
- R12: In slave mode (bit 0 of address 1 clear), a falling `spi_ss_n_i` starts a frame. `spi_miso_o` carries the oldest transmit byte, or 0 if the ring is empty, MSB first. Each bit changes after a falling SCLK. `spi_mosi_i` is sampled on rising SCLK, and every 8 bits form one received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 4 | Register address |
| host_wr_en | input | 1 | Register write strobe |
| host_rd_en | input | 1 | Register read strobe (pops at address 0) |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data, combinational from address |
| irq_o | output | 1 | Shared level interrupt |
| spi_sclk_o | output | 1 | Serial clock in master mode |
| spi_mosi_o | output | 1 | Serial data out in master mode |
| spi_ss_n_o | output | 1 | Slave select in master mode, active low |
| spi_miso_i | input | 1 | Serial data in for master mode |
| spi_sclk_i | input | 1 | Serial clock from an external master |
| spi_ss_n_i | input | 1 | Slave select from an external master |
| spi_mosi_i | input | 1 | Serial data in for slave mode |
| spi_miso_o | output | 1 | Serial data out in slave mode |

## Verification
A stale or wrong ring pointer shows up as wrong byte order on the line or at the data register. It appears at the first wrap of the window, which comes after only two bytes with a two-slot window. A wrong ring count moves `irq_o` and the flags within two clocks of the count change. A wrong divider or bit counter changes the measured slave-select low time during the very first frame. A wrong clear priority shows up in the single cycle right after a write-one-to-clear. The master sweeps are walked from a vector table, and directed cases follow for the window bounds, the full rings and both clock speeds.

// File: rtl/spi_tc_pkg.sv
// Package: register map, control/status bit positions and the master
// state type shared by the buffered SPI engine and its checker.
package spi_tc_pkg;
    localparam int RA_W = 4;

    localparam logic [RA_W-1:0] RA_DATA  = 4'd0;
    localparam logic [RA_W-1:0] RA_CTRL  = 4'd1;
    localparam logic [RA_W-1:0] RA_DIV   = 4'd2;
    localparam logic [RA_W-1:0] RA_TXLVL = 4'd3;
    localparam logic [RA_W-1:0] RA_RXLVL = 4'd4;
    localparam logic [RA_W-1:0] RA_WLO   = 4'd5;
    localparam logic [RA_W-1:0] RA_WHI   = 4'd6;
    localparam logic [RA_W-1:0] RA_RXCNT = 4'd7;
    localparam logic [RA_W-1:0] RA_TXCNT = 4'd8;
    localparam logic [RA_W-1:0] RA_STAT  = 4'd9;
    localparam logic [RA_W-1:0] RA_SRC   = 4'd10;

    localparam int CB_MASTER = 0;
    localparam int CB_TXFL   = 1;
    localparam int CB_RXFL   = 2;

    localparam int FB_TX  = 0;
    localparam int FB_RX  = 1;
    localparam int FB_OVF = 2;
    localparam int FB_OVR = 3;
    localparam int FB_N   = 4;

    typedef enum logic [1:0] {MS_IDLE, MS_SHIFT, MS_GAP} mst_state_t;
endpackage

// File: rtl/spi_ring_fifo.sv
// Ring buffer whose slots run between lo_i and hi_i inclusive.
// Assumes hi_i >= lo_i and that software flushes after moving the window.
// Flush has priority over push and pop. A push into a full ring is ignored.
module spi_ring_fifo #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lo_i,
    input  logic [AW-1:0] hi_i,
    input  logic          flush_i,
    input  logic          push_i,
    input  logic [DW-1:0] din_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic [AW:0]   count_o,
    output logic          empty_o,
    output logic          full_o
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p,
                                           input logic [AW-1:0] lo,
                                           input logic [AW-1:0] hi);
        return (p == hi) ? lo : p + 1'b1;
    endfunction

    // Capacity, occupancy flags and accepted operations
    assign cap     = CW'(hi_i) - CW'(lo_i) + 1'b1;
    assign empty_o = (count_o == '0);
    assign full_o  = (count_o == cap);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem[rd_ptr];

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push && !flush_i) mem[wr_ptr] <= din_i;
    end

    // Pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_o <= '0;
        end else if (flush_i) begin
            wr_ptr  <= lo_i;
            rd_ptr  <= lo_i;
            count_o <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr, lo_i, hi_i);
            if (do_pop)  rd_ptr <= step(rd_ptr, lo_i, hi_i);
            if (do_push && !do_pop)      count_o <= count_o + 1'b1;
            else if (do_pop && !do_push) count_o <= count_o - 1'b1;
        end
    end
endmodule

// File: rtl/spi_flag_bank.sv
// Sticky status bits. Each bit sets on its event and clears on a
// write-one-to-clear. The clear wins for one cycle, so a condition that
// persists sets the bit again on the following cycle.
module spi_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        // One sticky bit with clear priority
        always_ff @(posedge clk) begin
            if (!rst_n)         flag_o[g] <= 1'b0;
            else if (clr_i[g])  flag_o[g] <= 1'b0;
            else if (set_i[g])  flag_o[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
// Serial shifter for SPI mode 0 (SCLK idles low, sample on rise, shift on fall),
// 8-bit MSB-first frames.
// Master: starts a frame when the transmit ring is non-empty and holds SCLK
// high and low for speed+1 clocks each. A one-half-period gap follows each frame.
// Slave: slave-select, SCLK and MOSI pass through two-flop synchronisers. It
// assumes the external SCLK half period is longer than about four system clocks.
// The slave shows the head byte's MSB before the first rising SCLK and pops
// the byte on that rising edge.
module spi_shift_engine
    import spi_tc_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            master_i,
    input  logic [DIVW-1:0] speed_i,
    input  logic            tx_empty_i,
    input  logic [DW-1:0]   tx_byte_i,
    output logic            tx_pop_o,
    output logic            rx_push_o,
    output logic [DW-1:0]   rx_byte_o,
    output logic            sclk_o,
    output logic            mosi_o,
    output logic            ss_n_o,
    input  logic            miso_i,
    input  logic            sclk_i,
    input  logic            ss_n_i,
    input  logic            mosi_i,
    output logic            miso_o
);
    localparam int BW = $clog2(DW);
    localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

    mst_state_t      m_state;
    logic [DIVW-1:0] div_cnt;
    logic            m_sclk, m_ss_n;
    logic [DW-1:0]   m_tx, m_rx;
    logic [BW-1:0]   m_bit;
    logic            div_hit, m_start, m_done;

    logic [2:0]      sclk_sync, ss_sync;
    logic [1:0]      mosi_sync;
    logic [DW-1:0]   s_tx, s_rx;
    logic [BW-1:0]   s_bit;
    logic            s_active, s_ss_fall, s_rise, s_fall, s_done;
    logic [DW-1:0]   s_head;

    // Master control strobes
    assign div_hit = (div_cnt == speed_i);
    assign m_start = master_i && (m_state == MS_IDLE) && !tx_empty_i;
    assign m_done  = (m_state == MS_SHIFT) && div_hit && m_sclk && (m_bit == LAST_BIT);

    // Slave edge detection on synchronised inputs
    assign s_active  = !master_i && !ss_sync[1];
    assign s_ss_fall = !master_i && ss_sync[2] && !ss_sync[1];
    assign s_rise    = s_active && !sclk_sync[2] && sclk_sync[1];
    assign s_fall    = s_active && sclk_sync[2] && !sclk_sync[1];
    assign s_done    = s_rise && (s_bit == LAST_BIT);
    assign s_head    = tx_empty_i ? '0 : tx_byte_i;

    // Ring handshakes and received byte
    assign tx_pop_o  = m_start || (s_rise && (s_bit == '0) && !tx_empty_i);
    assign rx_push_o = m_done || s_done;
    assign rx_byte_o = m_done ? m_rx : {s_rx[DW-2:0], mosi_sync[1]};

    // Pin drive
    assign sclk_o = m_sclk;
    assign ss_n_o = m_ss_n;
    assign mosi_o = m_tx[DW-1];
    assign miso_o = !s_active ? 1'b0 : ((s_bit == '0) ? s_head[DW-1] : s_tx[DW-1]);

    // Master sequencer: divider, clock toggling and shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_state <= MS_IDLE;
            div_cnt <= '0;
            m_sclk  <= 1'b0;
            m_ss_n  <= 1'b1;
            m_tx    <= '0;
            m_rx    <= '0;
            m_bit   <= '0;
        end else begin
            case (m_state)
                MS_IDLE: begin
                    if (m_start) begin
                        m_state <= MS_SHIFT;
                        m_ss_n  <= 1'b0;
                        m_sclk  <= 1'b0;
                        div_cnt <= '0;
                        m_bit   <= '0;
                        m_tx    <= tx_byte_i;
                    end
                end
                MS_SHIFT: begin
                    if (div_hit) begin
                        div_cnt <= '0;
                        m_sclk  <= ~m_sclk;
                        if (!m_sclk) begin
                            m_rx <= {m_rx[DW-2:0], miso_i};
                        end else if (m_bit == LAST_BIT) begin
                            m_state <= MS_GAP;
                            m_ss_n  <= 1'b1;
                        end else begin
                            m_bit <= m_bit + 1'b1;
                            m_tx  <= {m_tx[DW-2:0], 1'b0};
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: begin
                    if (div_hit) begin
                        div_cnt <= '0;
                        m_state <= MS_IDLE;
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Slave input synchronisers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sync <= '0;
            ss_sync   <= '1;
            mosi_sync <= '0;
        end else begin
            sclk_sync <= {sclk_sync[1:0], sclk_i};
            ss_sync   <= {ss_sync[1:0], ss_n_i};
            mosi_sync <= {mosi_sync[0], mosi_i};
        end
    end

    // Slave shifter: capture on rise, advance output on fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_tx  <= '0;
            s_rx  <= '0;
            s_bit <= '0;
        end else if (s_ss_fall) begin
            s_bit <= '0;
        end else begin
            if (s_rise) begin
                s_rx  <= {s_rx[DW-2:0], mosi_sync[1]};
                s_bit <= (s_bit == LAST_BIT) ? '0 : s_bit + 1'b1;
                if (s_bit == '0) s_tx <= s_head;
            end
            if (s_fall && (s_bit != '0)) s_tx <= {s_tx[DW-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spi_thresh_ctrl.sv
// Top level: host register file, transmit and receive rings sharing one
// slot window, level flags with a shared interrupt, and the serial shifter.
// Register map is in spi_tc_pkg. Assumes AW+1 <= DW so levels fit a write.
module spi_thresh_ctrl
    import spi_tc_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RA_W-1:0] host_addr,
    input  logic            host_wr_en,
    input  logic            host_rd_en,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    output logic            irq_o,
    output logic            spi_sclk_o,
    output logic            spi_mosi_o,
    output logic            spi_ss_n_o,
    input  logic            spi_miso_i,
    input  logic            spi_sclk_i,
    input  logic            spi_ss_n_i,
    input  logic            spi_mosi_i,
    output logic            spi_miso_o
);
    localparam int CW = AW + 1;

    logic            master_q;
    logic [DW-1:0]   speed_q;
    logic [CW-1:0]   tx_lvl_q, rx_lvl_q;
    logic [AW-1:0]   win_lo_q, win_hi_q;

    logic            host_push, host_pop, tx_flush, rx_flush;
    logic [DW-1:0]   tx_head, rx_head, eng_rx_byte;
    logic [CW-1:0]   tx_cnt, rx_cnt;
    logic            tx_empty, tx_full, rx_empty, rx_full;
    logic            eng_tx_pop, eng_rx_push;
    logic [FB_N-1:0] flag_set, flag_clr, flags;

    // Host strobes decoded from address
    assign host_push = host_wr_en && (host_addr == RA_DATA);
    assign host_pop  = host_rd_en && (host_addr == RA_DATA);
    assign tx_flush  = host_wr_en && (host_addr == RA_CTRL) && host_wdata[CB_TXFL];
    assign rx_flush  = host_wr_en && (host_addr == RA_CTRL) && host_wdata[CB_RXFL];
    assign flag_clr  = (host_wr_en && (host_addr == RA_STAT)) ? host_wdata[FB_N-1:0] : '0;

    // Flag set conditions: levels and dropped bytes
    always_comb begin
        flag_set         = '0;
        flag_set[FB_TX]  = (tx_cnt < tx_lvl_q);
        flag_set[FB_RX]  = (rx_cnt > rx_lvl_q);
        flag_set[FB_OVF] = host_push && tx_full;
        flag_set[FB_OVR] = eng_rx_push && rx_full;
    end

    assign irq_o = flags[FB_TX] | flags[FB_RX];

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= 1'b0;
            speed_q  <= '0;
            tx_lvl_q <= '0;
            rx_lvl_q <= '0;
            win_lo_q <= '0;
            win_hi_q <= '1;
        end else if (host_wr_en) begin
            case (host_addr)
                RA_CTRL:  master_q <= host_wdata[CB_MASTER];
                RA_DIV:   speed_q  <= host_wdata;
                RA_TXLVL: tx_lvl_q <= host_wdata[CW-1:0];
                RA_RXLVL: rx_lvl_q <= host_wdata[CW-1:0];
                RA_WLO:   win_lo_q <= host_wdata[AW-1:0];
                RA_WHI:   win_hi_q <= host_wdata[AW-1:0];
                default: ;
            endcase
        end
    end

    // Read-data multiplexer
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            RA_DATA:  host_rdata = rx_empty ? '0 : rx_head;
            RA_CTRL:  host_rdata = DW'(master_q);
            RA_DIV:   host_rdata = speed_q;
            RA_TXLVL: host_rdata = DW'(tx_lvl_q);
            RA_RXLVL: host_rdata = DW'(rx_lvl_q);
            RA_WLO:   host_rdata = DW'(win_lo_q);
            RA_WHI:   host_rdata = DW'(win_hi_q);
            RA_RXCNT: host_rdata = DW'(rx_cnt);
            RA_TXCNT: host_rdata = DW'(tx_cnt);
            RA_STAT:  host_rdata = DW'(flags);
            RA_SRC:   host_rdata = DW'({flags[FB_RX], flags[FB_TX]});
            default:  host_rdata = '0;
        endcase
    end

    spi_ring_fifo #(.DW(DW), .AW(AW)) u_tx_ring (
        .clk(clk), .rst_n(rst_n), .lo_i(win_lo_q), .hi_i(win_hi_q),
        .flush_i(tx_flush), .push_i(host_push), .din_i(host_wdata),
        .pop_i(eng_tx_pop), .head_o(tx_head), .count_o(tx_cnt),
        .empty_o(tx_empty), .full_o(tx_full)
    );

    spi_ring_fifo #(.DW(DW), .AW(AW)) u_rx_ring (
        .clk(clk), .rst_n(rst_n), .lo_i(win_lo_q), .hi_i(win_hi_q),
        .flush_i(rx_flush), .push_i(eng_rx_push), .din_i(eng_rx_byte),
        .pop_i(host_pop), .head_o(rx_head), .count_o(rx_cnt),
        .empty_o(rx_empty), .full_o(rx_full)
    );

    spi_flag_bank #(.N(FB_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr), .flag_o(flags)
    );

    spi_shift_engine #(.DW(DW), .DIVW(DW)) u_engine (
        .clk(clk), .rst_n(rst_n), .master_i(master_q), .speed_i(speed_q),
        .tx_empty_i(tx_empty), .tx_byte_i(tx_head), .tx_pop_o(eng_tx_pop),
        .rx_push_o(eng_rx_push), .rx_byte_o(eng_rx_byte),
        .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o), .ss_n_o(spi_ss_n_o),
        .miso_i(spi_miso_i), .sclk_i(spi_sclk_i), .ss_n_i(spi_ss_n_i),
        .mosi_i(spi_mosi_i), .miso_o(spi_miso_o)
    );
endmodule

// File: rtl/spi_thresh_ctrl_chk.sv
// Checker for spi_thresh_ctrl, attached by bind. It watches the pins, the
// host read path and the ring and flag state across clock cycles.
module spi_thresh_ctrl_chk
    import spi_tc_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sclk_o,
    input logic            ss_n_o,
    input logic            irq,
    input logic [RA_W-1:0] host_addr,
    input logic [DW-1:0]   host_rdata,
    input logic [AW:0]     tx_cnt,
    input logic [AW:0]     rx_cnt,
    input logic [AW:0]     tx_lvl,
    input logic [AW:0]     rx_lvl,
    input logic            tx_full,
    input logic            rx_full,
    input logic            host_push,
    input logic            rx_push,
    input logic            tx_flush,
    input logic [FB_N-1:0] flags,
    input logic [FB_N-1:0] clr
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_o |-> !sclk_o);                                                    // R2
    AST_TX_LEVEL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt < tx_lvl && !clr[FB_TX]) |=> flags[FB_TX]);                      // R4
    AST_RX_LEVEL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt > rx_lvl && !clr[FB_RX]) |=> flags[FB_RX]);                      // R5
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr[FB_TX] |=> !flags[FB_TX]);                                           // R6
    AST_SOURCE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == RA_SRC) |-> (irq == (host_rdata[1:0] != 2'b00)));         // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (host_push && tx_full && !clr[FB_OVF]) |=> flags[FB_OVF]);              // R9
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !clr[FB_OVR]) |=> flags[FB_OVR]);                // R10
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> (tx_cnt == '0));                                            // R11
endmodule

bind spi_thresh_ctrl spi_thresh_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk_o(spi_sclk_o), .ss_n_o(spi_ss_n_o),
    .irq(irq_o), .host_addr(host_addr), .host_rdata(host_rdata),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_lvl(tx_lvl_q), .rx_lvl(rx_lvl_q),
    .tx_full(tx_full), .rx_full(rx_full), .host_push(host_push),
    .rx_push(eng_rx_push), .tx_flush(tx_flush), .flags(flags), .clr(flag_clr)
);

// File: tb/spi_thresh_ctrl_bench.sv
// Self-checking bench: table-driven master frames, then directed slave,
// level, window and overflow cases.
module spi_thresh_ctrl_bench;
    import spi_tc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] host_addr = '0;
    logic       host_wr_en = 1'b0;
    logic       host_rd_en = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_o;
    logic       spi_sclk_o, spi_mosi_o, spi_ss_n_o, spi_miso_o;
    logic       spi_miso_i = 1'b0;
    logic       spi_sclk_i = 1'b0;
    logic       spi_ss_n_i = 1'b1;
    logic       spi_mosi_i = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [7:0] cur_reply = '0;
    logic [7:0] bs_sh = '0;
    logic [7:0] bs_cap = '0;
    int         lowcnt = 0;
    logic       clr_low = 1'b0;

    // Master table: {speed, byte sent by host, byte returned by model slave}
    localparam logic [23:0] MVEC [4] = '{
        {8'd0, 8'hA5, 8'h5A},
        {8'd1, 8'h81, 8'h7E},
        {8'd3, 8'h00, 8'hFF},
        {8'd2, 8'hC3, 8'h96}
    };

    always #10 clk = ~clk;

    spi_thresh_ctrl u_spi_thresh_ctrl (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr_en(host_wr_en),
        .host_rd_en(host_rd_en), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_o(irq_o), .spi_sclk_o(spi_sclk_o), .spi_mosi_o(spi_mosi_o),
        .spi_ss_n_o(spi_ss_n_o), .spi_miso_i(spi_miso_i), .spi_sclk_i(spi_sclk_i),
        .spi_ss_n_i(spi_ss_n_i), .spi_mosi_i(spi_mosi_i), .spi_miso_o(spi_miso_o)
    );

    // Model slave for master-mode frames
    always @(negedge spi_ss_n_o) begin
        bs_sh = cur_reply;
        spi_miso_i = bs_sh[7];
    end
    always @(posedge spi_sclk_o) if (!spi_ss_n_o) bs_cap = {bs_cap[6:0], spi_mosi_o};
    always @(negedge spi_sclk_o) if (!spi_ss_n_o) begin
        bs_sh = {bs_sh[6:0], 1'b0};
        spi_miso_i = bs_sh[7];
    end

    // Slave-select low-time counter
    always @(posedge clk) begin
        if (clr_low) lowcnt <= 0;
        else if (!spi_ss_n_o) lowcnt <= lowcnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd_en = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd_en = 1'b0;
    endtask

    task automatic slave_xfer(input logic [7:0] mo, output logic [7:0] mi);
        @(negedge clk);
        spi_ss_n_i = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            spi_mosi_i = mo[i];
            repeat (8) @(negedge clk);
            mi[i] = spi_miso_o;
            spi_sclk_i = 1'b1;
            repeat (8) @(negedge clk);
            spi_sclk_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        spi_ss_n_i = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] d, m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 ss_n", 32'(spi_ss_n_o), 1);
        chk("R1 sclk", 32'(spi_sclk_o), 0);
        chk("R1 irq", 32'(irq_o), 0);
        reg_read(RA_RXCNT, d); chk("R1 rxcnt", 32'(d), 0);
        reg_read(RA_TXCNT, d); chk("R1 txcnt", 32'(d), 0);
        reg_read(RA_STAT, d);  chk("R1 status", 32'(d), 0);

        // R2/R3: master frames from the vector table
        reg_write(RA_CTRL, 8'h01);
        for (int v = 0; v < 4; v++) begin
            cur_reply = MVEC[v][7:0];
            reg_write(RA_DIV, MVEC[v][23:16]);
            clr_low = 1'b1;
            @(negedge clk);
            clr_low = 1'b0;
            reg_write(RA_DATA, MVEC[v][15:8]);
            d = 0;
            for (int k = 0; k < 400 && d == 0; k++) reg_read(RA_RXCNT, d);
            chk("R2 ss low time", 32'(lowcnt), 32'(16 * (MVEC[v][23:16] + 1)));
            chk("R2 mosi byte", 32'(bs_cap), 32'(MVEC[v][15:8]));
            reg_read(RA_DATA, d); chk("R3 miso byte", 32'(d), 32'(MVEC[v][7:0]));
            reg_read(RA_RXCNT, d); chk("R3 count after pop", 32'(d), 0);
            repeat (10) @(negedge clk);
        end
        reg_write(RA_CTRL, 8'h00);
        repeat (10) @(negedge clk);

        // R3: empty read returns zero and changes nothing
        reg_read(RA_DATA, d);  chk("R3 empty read", 32'(d), 0);
        reg_read(RA_RXCNT, d); chk("R3 empty count", 32'(d), 0);

        // R12: slave frame
        reg_write(RA_DATA, 8'hA5);
        slave_xfer(8'h3C, m);
        chk("R12 miso byte", 32'(m), 32'h A5);
        reg_read(RA_DATA, d); chk("R12 mosi byte", 32'(d), 32'h3C);
        reg_read(RA_TXCNT, d); chk("R12 tx drained", 32'(d), 0);
        slave_xfer(8'hC1, m);
        chk("R12 empty ring sends zero", 32'(m), 0);
        reg_read(RA_DATA, d); chk("R12 second byte", 32'(d), 32'hC1);

        // R4/R6/R7: transmit level flag
        reg_write(RA_STAT, 8'h0F);
        reg_write(RA_TXLVL, 8'd4);
        repeat (2) @(negedge clk);
        chk("R4 tx flag irq", 32'(irq_o), 1);
        reg_read(RA_SRC, d); chk("R7 source tx", 32'(d), 1);
        reg_write(RA_STAT, 8'h01);
        chk("R6 cleared cycle", 32'(irq_o), 0);
        @(negedge clk);
        chk("R6 re-assert", 32'(irq_o), 1);
        for (int i = 0; i < 4; i++) reg_write(RA_DATA, 8'(8'h10 + i));
        reg_write(RA_STAT, 8'h01);
        repeat (3) @(negedge clk);
        chk("R4 level reached irq", 32'(irq_o), 0);
        reg_read(RA_STAT, d); chk("R4 level reached status", 32'(d), 0);

        // R11: flush transmit ring
        reg_write(RA_CTRL, 8'h02);
        reg_read(RA_TXCNT, d); chk("R11 tx flushed", 32'(d), 0);
        reg_write(RA_TXLVL, 8'd0);
        reg_write(RA_STAT, 8'h0F);

        // R5/R7: receive level flag
        reg_write(RA_RXLVL, 8'd2);
        slave_xfer(8'h61, m);
        slave_xfer(8'h62, m);
        reg_read(RA_STAT, d); chk("R5 equal level clear", 32'(d), 0);
        slave_xfer(8'h63, m);
        reg_read(RA_STAT, d); chk("R5 above level", 32'(d), 2);
        reg_read(RA_SRC, d);  chk("R7 source rx", 32'(d), 2);
        chk("R7 irq rx", 32'(irq_o), 1);
        for (int i = 0; i < 3; i++) begin
            reg_read(RA_DATA, d); chk("R3 fifo order", 32'(d), 32'(8'h61 + i));
        end
        reg_write(RA_STAT, 8'h0F);
        @(negedge clk);
        chk("R6 rx cleared stays low", 32'(irq_o), 0);

        // R8/R9: two-slot window, overflow and wrap
        reg_write(RA_WLO, 8'd10);
        reg_write(RA_WHI, 8'd11);
        reg_write(RA_CTRL, 8'h06);
        reg_write(RA_DATA, 8'h11);
        reg_write(RA_DATA, 8'h22);
        reg_write(RA_DATA, 8'h33);
        reg_read(RA_TXCNT, d); chk("R8 capacity", 32'(d), 2);
        reg_read(RA_STAT, d);  chk("R9 overflow bit", 32'(d & 8'h04), 4);
        slave_xfer(8'h01, m); chk("R8 first out", 32'(m), 32'h11);
        slave_xfer(8'h02, m); chk("R9 dropped byte absent", 32'(m), 32'h22);
        reg_read(RA_DATA, d); reg_read(RA_DATA, d);
        reg_write(RA_DATA, 8'h44);
        reg_write(RA_DATA, 8'h55);
        slave_xfer(8'h03, m); chk("R8 wrap order a", 32'(m), 32'h44);
        slave_xfer(8'h04, m); chk("R8 wrap order b", 32'(m), 32'h55);
        reg_read(RA_DATA, d); chk("R8 rx wrap a", 32'(d), 32'h03);
        reg_read(RA_DATA, d); chk("R8 rx wrap b", 32'(d), 32'h04);
        reg_write(RA_STAT, 8'h0F);

        // R10: receive overrun
        slave_xfer(8'hD1, m);
        slave_xfer(8'hD2, m);
        slave_xfer(8'hD3, m);
        reg_read(RA_RXCNT, d); chk("R10 count held", 32'(d), 2);
        reg_read(RA_STAT, d);  chk("R10 overrun bit", 32'(d & 8'h08), 8);
        reg_read(RA_DATA, d);  chk("R10 oldest kept", 32'(d), 32'hD1);

        // R11: flush receive ring
        reg_write(RA_CTRL, 8'h04);
        reg_read(RA_RXCNT, d); chk("R11 rx flushed", 32'(d), 0);

        finish_run();
    end
endmodule